// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block produces the periodic interrupt and the once-per-second update strobe of a real-time clock. A 15-stage binary divider advances once per pulse of a 32.768 kHz time-base enable. The divider runs in the system clock domain. A 4-bit rate code picks the divider stage that raises the periodic flag. The flag is gated with its enable to drive an active-high interrupt line. An alarm flag from outside logic is gated with its own enable and drives the same line.

Software reaches three byte-wide registers through a simple bus: a rate register, a control register and a flag register that clears when it is read. A freeze bit in the control register holds back the update strobe so that time registers elsewhere can be rewritten safely. That bit keeps its value across reset. The divider counts without break, so a new rate code only moves the point at which the next flag is raised.

Top module: `rtc_periodic_irq`

## Requirements
- R1: Rate code 0 disables the periodic event: the periodic flag never sets, however long the divider runs.
- R2: Rate codes 3 to 15 raise the periodic flag every 2^(code-1) time-base pulses, at the edge where the low (code-1) divider bits are all ones. The divider counts time-base pulses from zero after reset.
- R3: Rate code 1 behaves like code 8 (period 128 pulses) and code 2 behaves like code 9 (period 256 pulses).
- R4: Reading the flag register (address 2, `reg_rd` high) returns the interrupt state in bit 7, the periodic flag in bit 6 and the alarm flag in bit 5, and clears both flags at that edge. A periodic event in the same cycle as the read wins, and the flag stays set.
- R5: The periodic flag sets whether or not its enable (control bit 6) is set. `irq` is high exactly while (periodic flag and periodic enable) or (alarm flag and alarm enable, control bit 5) holds. `alarm_en` mirrors the alarm enable.
- R6: Reset clears the rate code, both enables, both flags and the divider. The freeze bit (control bit 7) keeps its value. The periodic enable changes only through a write to the control register (address 1).
- R7: With the freeze bit at 0, `upd_strobe` is high for exactly one cycle after each edge at which all 15 divider bits are ones. With the freeze bit at 1 it stays low.
- R8: A new rate code, written to address 0 bits 3:0, takes effect at the next all-ones point of the newly chosen stage of the running divider, with no restart of the count and no spurious flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| tb_en | input | 1 | One-cycle pulse per 32.768 kHz time-base period |
| alarm_hit | input | 1 | Alarm match pulse from the comparison logic |
| reg_addr | input | 2 | Register select: 0 rate, 1 control, 2 flags |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 2 clears the flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pf | output | 1 | Periodic flag |
| alarm_en | output | 1 | Alarm interrupt enable |
| upd_strobe | output | 1 | Once-per-second update strobe |
| irq | output | 1 | Combined active-high interrupt |

## Verification
A scoreboard predicts the cycle of every periodic flag rise from a model of the pulse count. The prediction is made across the fastest codes, the two aliased low codes, the codes they alias, a mid code and the slowest code. Getting a stage wrong, or mapping an alias to the wrong stage, shows up as a rise in the wrong cycle. Each rate switch lands at an arbitrary divider phase, so a restart of the divider on a write would shift the first predicted tick. Separate patterns cover code 0 left running, a read that collides with a tick, enable combinations for both flags, a reset with the freeze bit held, and a full-second carry with the freeze bit set and then clear.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;

  typedef enum logic [1:0] {
    RA_RATE = 2'd0,
    RA_CTRL = 2'd1,
    RA_FLAG = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam int CTRL_FRZ_BIT = 7;
  localparam int CTRL_PEN_BIT = 6;
  localparam int CTRL_AEN_BIT = 5;

  localparam int FLAG_IRQ_BIT = 7;
  localparam int FLAG_PF_BIT  = 6;
  localparam int FLAG_AF_BIT  = 5;

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en_i,
  input  logic             freeze_i,
  output logic [DIV_W:0]   ones_o,
  output logic             upd_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W:0]   ones;
  logic             upd_d;
  logic             upd_q;

  // ones[k] is high when the low k divider bits are all set
  assign ones[0] = 1'b1;
  for (genvar k = 0; k < DIV_W; k++) begin : g_chain
    assign ones[k+1] = ones[k] & cnt_q[k];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (tb_en_i) begin
      cnt_d = cnt_q + DIV_W'(1);
    end
    upd_d = tb_en_i & ones[DIV_W] & ~freeze_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      upd_q <= upd_d;
    end
  end

  assign ones_o = ones;
  assign upd_o  = upd_q;

  // R7: a strobe only follows a cycle in which the freeze bit was clear
  a_r7_no_update_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> $past(!freeze_i));

  // R7: the strobe lasts a single cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);

endmodule

// File: rtl/rtc_rate_sel.sv
module rtc_rate_sel #(
  parameter int DIV_W       = 15,
  parameter int RATE_W      = 4,
  parameter int ALIAS_A_STG = 7,
  parameter int ALIAS_B_STG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [DIV_W:0]    ones_i,
  output logic              tick_o
);

  localparam int STG_W = $clog2(DIV_W + 1);

  logic             sel_en;
  logic [STG_W-1:0] sel_stg;

  always_comb begin
    sel_en  = 1'b1;
    sel_stg = '0;
    if (rate_i == '0) begin
      sel_en = 1'b0;
    end else if (rate_i == RATE_W'(1)) begin
      sel_stg = STG_W'(ALIAS_A_STG);
    end else if (rate_i == RATE_W'(2)) begin
      sel_stg = STG_W'(ALIAS_B_STG);
    end else begin
      sel_stg = STG_W'(rate_i) - STG_W'(1);
    end
  end

  assign tick_o = tb_en_i & sel_en & ones_i[sel_stg];

  // R1: code zero never produces a periodic event
  a_r1_off_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0) |-> !tick_o);

  // R2: every event sits on an odd divider value (stage one or higher)
  a_r2_tick_on_odd_count: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> ones_i[1]);

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pi_pkg::*;
#(
  parameter int RATE_W = 4,
  parameter int DATA_W = 8,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              tick_i,
  input  logic              alarm_hit_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              freeze_o,
  output logic              pen_o,
  output logic              aen_o,
  output logic              pf_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] reg_rdata_o
);

  logic              wr_rate;
  logic              wr_ctrl;
  logic              rd_flag;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              frz_q, frz_d;
  logic              pen_q, pen_d;
  logic              aen_q, aen_d;
  logic              pf_q, pf_d;
  logic              af_q, af_d;
  logic              irq;

  always_comb begin
    wr_rate = reg_wr_i & (reg_addr_e'(reg_addr_i) == RA_RATE);
    wr_ctrl = reg_wr_i & (reg_addr_e'(reg_addr_i) == RA_CTRL);
    rd_flag = reg_rd_i & (reg_addr_e'(reg_addr_i) == RA_FLAG);

    rate_d = rate_q;
    frz_d  = frz_q;
    pen_d  = pen_q;
    aen_d  = aen_q;
    if (wr_rate) begin
      rate_d = reg_wdata_i[RATE_W-1:0];
    end
    if (wr_ctrl) begin
      frz_d = reg_wdata_i[CTRL_FRZ_BIT];
      pen_d = reg_wdata_i[CTRL_PEN_BIT];
      aen_d = reg_wdata_i[CTRL_AEN_BIT];
    end

    // a new event in the read cycle outranks the clear
    pf_d = tick_i      | (pf_q & ~rd_flag);
    af_d = alarm_hit_i | (af_q & ~rd_flag);

    irq = (pf_q & pen_q) | (af_q & aen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      pen_q  <= 1'b0;
      aen_q  <= 1'b0;
      pf_q   <= 1'b0;
      af_q   <= 1'b0;
    end else begin
      rate_q <= rate_d;
      pen_q  <= pen_d;
      aen_q  <= aen_d;
      pf_q   <= pf_d;
      af_q   <= af_d;
    end
  end

  // the freeze bit is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    frz_q <= frz_d;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      RA_RATE: reg_rdata_o[RATE_W-1:0] = rate_q;
      RA_CTRL: begin
        reg_rdata_o[CTRL_FRZ_BIT] = frz_q;
        reg_rdata_o[CTRL_PEN_BIT] = pen_q;
        reg_rdata_o[CTRL_AEN_BIT] = aen_q;
      end
      RA_FLAG: begin
        reg_rdata_o[FLAG_IRQ_BIT] = irq;
        reg_rdata_o[FLAG_PF_BIT]  = pf_q;
        reg_rdata_o[FLAG_AF_BIT]  = af_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign rate_o   = rate_q;
  assign freeze_o = frz_q;
  assign pen_o    = pen_q;
  assign aen_o    = aen_q;
  assign pf_o     = pf_q;
  assign irq_o    = irq;

  // R4: the flag only rises after a periodic event from the stage selector
  a_r4_pf_rise_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_q) |-> $past(tick_i));

  // R4: a flag read without a coincident event leaves the flag clear
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && !tick_i) |=> !pf_q);

  // R6: the periodic enable moves only on a control write
  a_r6_pen_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(pen_q));

  // R5: a set but masked periodic flag alone cannot raise the interrupt
  a_r5_masked_pf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pen_q && !af_q) |-> !irq_o);

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4,
  parameter int DATA_W = 8,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic              alarm_hit,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pf,
  output logic              alarm_en,
  output logic              upd_strobe,
  output logic              irq
);

  logic [DIV_W:0]    ones;
  logic [RATE_W-1:0] rate;
  logic              freeze;
  logic              pen;
  logic              tick;

  rtc_divider #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_en_i  (tb_en),
    .freeze_i (freeze),
    .ones_o   (ones),
    .upd_o    (upd_strobe)
  );

  rtc_rate_sel #(
    .DIV_W  (DIV_W),
    .RATE_W (RATE_W)
  ) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .tb_en_i (tb_en),
    .rate_i  (rate),
    .ones_i  (ones),
    .tick_o  (tick)
  );

  rtc_ctrl_regs #(
    .RATE_W (RATE_W),
    .DATA_W (DATA_W),
    .AW     (AW)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_wdata_i (reg_wdata),
    .tick_i      (tick),
    .alarm_hit_i (alarm_hit),
    .rate_o      (rate),
    .freeze_o    (freeze),
    .pen_o       (pen),
    .aen_o       (alarm_en),
    .pf_o        (pf),
    .irq_o       (irq),
    .reg_rdata_o (reg_rdata)
  );

  // R5: an unmasked periodic flag always reaches the interrupt line
  a_r5_pf_reaches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (pf && pen) |-> irq);

endmodule

// File: tb/sim_rtc_periodic_irq.sv
`timescale 1ns/1ps
module sim_rtc_periodic_irq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_en;
  logic       alarm_hit;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pf;
  logic       alarm_en;
  logic       upd_strobe;
  logic       irq;

  always #2.5 clk = ~clk;

  rtc_periodic_irq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_en      (tb_en),
    .alarm_hit  (alarm_hit),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pf         (pf),
    .alarm_en   (alarm_en),
    .upd_strobe (upd_strobe),
    .irq        (irq)
  );

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          upd_seen = 0;
  logic [14:0] tbc;
  logic        upd_exp;
  logic        frz_ref = 1'b1;
  bit          mon_on = 1'b0;
  logic        pf_prev = 1'b0;
  int          exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference pulse count (R2, R7)
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbc     <= '0;
      upd_exp <= 1'b0;
    end else begin
      if (tb_en) tbc <= tbc + 15'd1;
      upd_exp <= tb_en && (tbc == 15'h7fff) && !frz_ref;
    end
  end

  // monitor: periodic flag rises are popped from the scoreboard
  always @(negedge clk) begin
    if (mon_on && pf && !pf_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1/R2 unexpected periodic flag", cyc, -1);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cyc == e, t, cyc, e);
      end
    end
    pf_prev = pf;
    if (rst_n && (upd_strobe || upd_exp)) begin
      chk(upd_strobe == upd_exp, "R7 update strobe timing", int'(upd_strobe), int'(upd_exp));
      if (upd_strobe) upd_seen++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 2'd1) frz_ref = d[7];
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b0;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_flags(output logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = 2'd2; reg_rd = 1'b1;
    #0.5;
    d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  function automatic int stage_of(input int code);
    if (code == 1) return 7;
    if (code == 2) return 8;
    return code - 1;
  endfunction

  task automatic run_rate(input int code, input int n, input string req);
    logic [7:0] d;
    mon_on = 1'b0;
    wr(2'd0, 8'(code));
    rd_flags(d);
    while (pf) rd_flags(d);
    pf_prev = 1'b0;
    mon_on = 1'b1;
    for (int i = 0; i < n; i++) begin
      int per;
      int dd;
      per = 1 << stage_of(code);
      dd  = (per - 1) - (int'(tbc) & (per - 1));
      exp_q.push_back(cyc + dd + 1);
      tag_q.push_back(i == 0 ? {"R8 first tick after switch, ", req} : {req, " periodic tick"});
      while (exp_q.size() != 0) begin
        @(posedge clk); #1;
      end
      rd_flags(d);
      chk(d[6] == 1'b1, "R4 flag read shows periodic flag", int'(d[6]), 1);
      chk(pf == 1'b0, "R4 flag cleared by read", int'(pf), 0);
    end
    mon_on = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    int         u;
    rst_n = 1'b0; tb_en = 1'b1; alarm_hit = 1'b0;
    reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R6 reset state
    peek(2'd0, d); chk(d == 8'h00, "R6 rate after reset", d, 0);
    peek(2'd1, d); chk(d[6:5] == 2'b00, "R6 enables after reset", d[6:5], 0);
    peek(2'd2, d); chk(d == 8'h00, "R6 flags after reset", d, 0);
    chk(irq == 1'b0 && alarm_en == 1'b0, "R6 irq and alarm_en low", {irq, alarm_en}, 0);

    // R6: freeze bit survives reset, enables and rate do not
    wr(2'd1, 8'hE0);
    wr(2'd0, 8'h05);
    chk(alarm_en == 1'b1, "R5 alarm_en follows enable", alarm_en, 1);
    @(posedge clk); #1 rst_n = 1'b0;
    #1;
    peek(2'd1, d); chk(d == 8'h80, "R6 freeze kept, enables cleared", d, 8'h80);
    peek(2'd0, d); chk(d == 8'h00, "R6 rate cleared", d, 0);
    chk(alarm_en == 1'b0, "R6 alarm_en cleared", alarm_en, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // R5: flag sets with enable off, gating of both sources
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03);
    repeat (6) @(posedge clk);
    #1;
    wr(2'd0, 8'h00);
    chk(pf == 1'b1, "R5 flag sets with enable clear", pf, 1);
    chk(irq == 1'b0, "R5 irq masked when enable clear", irq, 0);
    wr(2'd1, 8'h40);
    chk(irq == 1'b1, "R5 irq with enabled flag", irq, 1);
    rd_flags(d);
    chk(d[7:6] == 2'b11, "R4 read shows irq and flag", d[7:6], 3);
    chk(pf == 1'b0 && irq == 1'b0, "R4 read clears flag and irq", {pf, irq}, 0);
    @(posedge clk); #1 alarm_hit = 1'b1;
    @(posedge clk); #1 alarm_hit = 1'b0;
    peek(2'd2, d); chk(d[5] == 1'b1, "R5 alarm flag set", d[5], 1);
    chk(irq == 1'b0, "R5 alarm masked when alarm enable clear", irq, 0);
    wr(2'd1, 8'h60);
    chk(irq == 1'b1, "R5 alarm drives irq when enabled", irq, 1);
    rd_flags(d);
    chk(d[5] == 1'b1 && irq == 1'b0, "R4 alarm flag read then cleared", {d[5], irq}, 2);
    wr(2'd1, 8'h40);

    // R4: read colliding with a tick keeps the flag
    wr(2'd0, 8'h03);
    while ((tbc & 15'd3) != 15'd3) begin
      @(posedge clk); #1;
    end
    reg_addr = 2'd2; reg_rd = 1'b1;
    @(posedge clk); #1 reg_rd = 1'b0;
    chk(pf == 1'b1, "R4 event wins over clear", pf, 1);

    // R2, R3, R8: periodic timing across codes
    run_rate(3, 4, "R2 code3");
    run_rate(4, 3, "R2 code4");
    run_rate(5, 3, "R2 code5");
    run_rate(1, 3, "R3 code1");
    run_rate(8, 2, "R3 code8");
    run_rate(2, 3, "R3 code2");
    run_rate(9, 2, "R3 code9");
    run_rate(11, 2, "R2 code11");

    // R1: code zero never sets the flag
    wr(2'd0, 8'h00);
    rd_flags(d);
    pf_prev = 1'b0;
    mon_on = 1'b1;
    repeat (5000) @(posedge clk);
    #1 mon_on = 1'b0;
    chk(pf == 1'b0, "R1 no flag with code zero", pf, 0);

    run_rate(15, 1, "R2 code15");

    // R7: update strobe suppressed by freeze, then resumed
    wr(2'd1, 8'hC0);
    u = upd_seen;
    while (tbc != 15'h7fff) begin
      @(posedge clk); #1;
    end
    repeat (5) @(posedge clk);
    #1;
    chk(upd_seen == u, "R7 no strobe while frozen", upd_seen, u);
    wr(2'd1, 8'h40);
    while (tbc != 15'h7fff) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(upd_seen == u + 1, "R7 one strobe per second", upd_seen, u + 1);

    finish_run();
  end

endmodule